// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This unit decides, for a group of local interrupt controllers, which ones accept an inter-processor interrupt request. One request is presented per cycle. It carries a destination field, a destination mode (physical or logical), a shorthand code, the vector and a one-hot mark of the sending core. Each core supplies its physical ID, the logical ID byte of its logical destination register and its destination format (flat or cluster). A global flag selects compatible (8-bit) or extended (32-bit) physical addressing.

A request produces a registered accept mask, one bit per core, and the vector to latch, one cycle later. The unit covers physical matching with aliased IDs, flat and cluster logical matching, the broadcast codes and the three shorthands. Arbitration among accepting cores and delivery modes other than fixed belong to other blocks.

Top module: `ipi_dest_match`

## Requirements
- R1: Outputs are registered. A request presented in cycle n shows in cycle n+1 as valid_o=1, its accept mask and vector_o equal to vector_i. A cycle with no request gives valid_o=0 and accept_o=0, and vector_o keeps its last value.
- R2: While reset is asserted, valid_o, accept_o and vector_o are all zero.
- R3: shorthand_i encodes 0 none, 1 self, 2 all including self, 3 all excluding self. With code 1 only the cores marked in sender_i accept, whatever the destination and mode.
- R4: With shorthand code 2 every core accepts, whatever the destination, mode and sender.
- R5: With shorthand code 3 every core not marked in sender_i accepts, and the sender does not.
- R6: In compatible physical mode (ext_mode_i=0, logical_i=0, shorthand 0) a core accepts when dest_i[7:0] equals bits 7:0 of its physical ID. dest_i[31:8] is ignored. Every core sharing that ID accepts.
- R7: In compatible physical mode dest_i[7:0]=0xFF is a broadcast that every core accepts.
- R8: In extended physical mode the whole 32-bit destination is compared with the whole physical ID, and only 0xFFFFFFFF is a broadcast. 0x000000FF is an ordinary ID there.
- R9: In flat logical mode (format bit 0) a core accepts when its logical ID byte ANDed with dest_i[7:0] is non-zero. Logical matching uses dest_i[7:0] in both compatible and extended mode.
- R10: In cluster logical mode (format bit 1) a core accepts when dest_i[7:4] equals bits 7:4 of its logical ID byte and dest_i[3:0] AND bits 3:0 of that byte is non-zero.
- R11: A logical destination dest_i[7:0]=0xFF is accepted by every core in both flat and cluster format.
- R12: The format is taken per core, so cores in flat and cluster format are matched under their own rules within one request.
- R13: Destination bits or IDs that name no core are ignored. They add no acceptance and do not stop delivery to the cores that do match, and an ID held by no core is accepted by none.
- R14: With shorthand code 0 the sender mark has no effect on the accept mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| dest_i | input | ID_W | Destination field |
| logical_i | input | 1 | 1 selects logical destination mode, 0 physical |
| shorthand_i | input | 2 | Shorthand code (0 none, 1 self, 2 all incl. self, 3 all excl. self) |
| vector_i | input | VEC_W | Interrupt vector |
| sender_i | input | NUM_CORES | One-hot mark of the sending core |
| ext_mode_i | input | 1 | 1 selects extended 32-bit physical addressing |
| phys_id_i | input | NUM_CORES*ID_W | Physical ID of each core, core 0 in the low bits |
| lid_i | input | NUM_CORES*8 | Logical ID byte (register bits 31:24) of each core |
| cluster_i | input | NUM_CORES | Destination format per core, 1 cluster, 0 flat |
| valid_o | output | 1 | Registered request valid |
| accept_o | output | NUM_CORES | Registered accept mask |
| vector_o | output | VEC_W | Vector to latch |

## Verification
The bench targets the places where address forms overlap. 0x000000FF in extended mode must not act as a broadcast. A design that tested only the low byte would flood every core there. Aliased physical IDs must reach both holders; a first-match encoder would deliver to one. The bench also mixes flat and cluster cores in one request, which catches a global format decode. It sends cluster destinations whose member bits are right and whose cluster is wrong, which catches a missing cluster compare. Logical 0xFF must reach every cluster, and a missed case leaves cores silent. Shorthand requests use a stray destination to show the destination is overridden. The exclude-self case would fire the sender if the polarity were inverted.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;
  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam int unsigned CMP_W = 8;   // compatible-mode ID width
  localparam int unsigned LID_W = 8;   // logical ID byte
endpackage

// File: rtl/ipi_phys_match.sv
module ipi_phys_match
  import ipi_match_pkg::*;
#(
  parameter int unsigned ID_W = 32
) (
  input  logic [ID_W-1:0] dest_i,
  input  logic [ID_W-1:0] own_id_i,
  input  logic            ext_mode_i,
  output logic            hit_o
);
  logic cmp_eq, ext_eq, cmp_bc, ext_bc;

  assign cmp_eq = (dest_i[CMP_W-1:0] == own_id_i[CMP_W-1:0]);
  assign ext_eq = (dest_i == own_id_i);
  assign cmp_bc = &dest_i[CMP_W-1:0];
  assign ext_bc = &dest_i;

  assign hit_o = ext_mode_i ? (ext_eq | ext_bc) : (cmp_eq | cmp_bc);
endmodule

// File: rtl/ipi_logic_match.sv
module ipi_logic_match
  import ipi_match_pkg::*;
(
  input  logic [LID_W-1:0] dest_i,
  input  logic [LID_W-1:0] lid_i,
  input  logic             cluster_i,
  output logic             hit_o
);
  localparam int unsigned HALF = LID_W / 2;

  logic             bcast, flat_hit, cl_hit;
  logic [HALF-1:0]  member_and;

  assign bcast    = &dest_i;
  assign flat_hit = |(dest_i & lid_i);

  for (genvar b = 0; b < HALF; b++) begin : g_member
    assign member_and[b] = dest_i[b] & lid_i[b];
  end

  assign cl_hit = (dest_i[LID_W-1:HALF] == lid_i[LID_W-1:HALF]) & (|member_and);

  assign hit_o = bcast | (cluster_i ? cl_hit : flat_hit);
endmodule

// File: rtl/ipi_core_slice.sv
module ipi_core_slice
  import ipi_match_pkg::*;
#(
  parameter int unsigned ID_W = 32
) (
  input  logic [ID_W-1:0]  dest_i,
  input  logic             logical_i,
  input  shorthand_e       shorthand_i,
  input  logic             is_sender_i,
  input  logic             ext_mode_i,
  input  logic [ID_W-1:0]  own_id_i,
  input  logic [LID_W-1:0] lid_i,
  input  logic             cluster_i,
  output logic             hit_o
);
  logic phys_hit, log_hit;

  ipi_phys_match #(.ID_W(ID_W)) u_phys (
    .dest_i    (dest_i),
    .own_id_i  (own_id_i),
    .ext_mode_i(ext_mode_i),
    .hit_o     (phys_hit)
  );

  ipi_logic_match u_log (
    .dest_i   (dest_i[LID_W-1:0]),
    .lid_i    (lid_i),
    .cluster_i(cluster_i),
    .hit_o    (log_hit)
  );

  always_comb begin
    unique case (shorthand_i)
      SH_SELF:   hit_o = is_sender_i;
      SH_ALL:    hit_o = 1'b1;
      SH_OTHERS: hit_o = ~is_sender_i;
      default:   hit_o = logical_i ? log_hit : phys_hit;
    endcase
  end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_match_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ID_W      = 32,
  parameter int unsigned VEC_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [ID_W-1:0]            dest_i,
  input  logic                       logical_i,
  input  logic [1:0]                 shorthand_i,
  input  logic [VEC_W-1:0]           vector_i,
  input  logic [NUM_CORES-1:0]       sender_i,
  input  logic                       ext_mode_i,
  input  logic [NUM_CORES*ID_W-1:0]  phys_id_i,
  input  logic [NUM_CORES*LID_W-1:0] lid_i,
  input  logic [NUM_CORES-1:0]       cluster_i,
  output logic                       valid_o,
  output logic [NUM_CORES-1:0]       accept_o,
  output logic [VEC_W-1:0]           vector_o
);
  shorthand_e           sh;
  logic [NUM_CORES-1:0] hit;
  logic                 valid_q;
  logic [NUM_CORES-1:0] acc_q;
  logic [VEC_W-1:0]     vec_q;

  assign sh = shorthand_e'(shorthand_i);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_core_slice #(.ID_W(ID_W)) u_slice (
      .dest_i     (dest_i),
      .logical_i  (logical_i),
      .shorthand_i(sh),
      .is_sender_i(sender_i[c]),
      .ext_mode_i (ext_mode_i),
      .own_id_i   (phys_id_i[c*ID_W +: ID_W]),
      .lid_i      (lid_i[c*LID_W +: LID_W]),
      .cluster_i  (cluster_i[c]),
      .hit_o      (hit[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      acc_q   <= '0;
      vec_q   <= '0;
    end else begin
      valid_q <= req_valid_i;
      acc_q   <= req_valid_i ? hit : '0;
      if (req_valid_i) vec_q <= vector_i;
    end
  end

  assign valid_o  = valid_q;
  assign accept_o = acc_q;
  assign vector_o = vec_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!valid_o && accept_o == '0));
  p_vec_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (valid_o && vector_o == $past(vector_i)));
  p_vec_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(vector_o));
  p_self_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd1) |=> accept_o == $past(sender_i));
  p_all_incl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd2) |=> &accept_o);
  p_all_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd3) |=> accept_o == ~$past(sender_i));
  p_cmp_bcast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd0 && !logical_i && !ext_mode_i &&
     &dest_i[CMP_W-1:0]) |=> &accept_o);
  p_ext_bcast_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd0 && !logical_i && ext_mode_i && &dest_i)
    |=> &accept_o);
  p_log_bcast_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && shorthand_i == 2'd0 && logical_i && &dest_i[LID_W-1:0])
    |=> &accept_o);
endmodule

// File: tb/tb_ipi_dest_match.sv
`timescale 1ns/1ps
module tb_ipi_dest_match;
  localparam int N = 4;
  localparam int IDW = 32;
  localparam int VW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [IDW-1:0]  dest = '0;
  logic            logical = 1'b0;
  logic [1:0]      sh = 2'd0;
  logic [VW-1:0]   vec = '0;
  logic [N-1:0]    sender = '0;
  logic            ext = 1'b0;
  logic [N*IDW-1:0] pid;
  logic [N*8-1:0]  lid;
  logic [N-1:0]    clus = '0;
  logic            valid_o;
  logic [N-1:0]    accept_o;
  logic [VW-1:0]   vector_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  ipi_dest_match #(.NUM_CORES(N), .ID_W(IDW), .VEC_W(VW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .dest_i(dest),
    .logical_i(logical), .shorthand_i(sh), .vector_i(vec), .sender_i(sender),
    .ext_mode_i(ext), .phys_id_i(pid), .lid_i(lid), .cluster_i(clus),
    .valid_o(valid_o), .accept_o(accept_o), .vector_o(vector_o)
  );

  // behavioural reference, one core at a time
  function automatic bit ref_core(int c);
    longint d   = longint'(dest);
    longint id  = longint'(pid[c*IDW +: IDW]);
    int     d8  = int'(dest[7:0]);
    int     l8  = int'(lid[c*8 +: 8]);
    case (sh)
      2'd1: return sender[c];
      2'd2: return 1'b1;
      2'd3: return !sender[c];
      default: ;
    endcase
    if (!logical) begin
      if (ext) return (d == 64'hFFFF_FFFF) || (d == id);
      return (d8 == 255) || (d8 == (id % 256));
    end
    if (d8 == 255) return 1'b1;
    if (!clus[c]) return (d8 & l8) != 0;
    return ((d8 / 16) == (l8 / 16)) && (((d8 % 16) & (l8 % 16)) != 0);
  endfunction

  logic [N-1:0]  m_acc;
  logic          m_valid;
  logic [VW-1:0] m_vec;
  string         m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= '0; m_valid <= 1'b0; m_vec <= '0; m_tag <= "R2";
    end else begin
      logic [N-1:0] t;
      for (int c = 0; c < N; c++) t[c] = req_valid ? ref_core(c) : 1'b0;
      m_acc   <= t;
      m_valid <= req_valid;
      if (req_valid) m_vec <= vec;
      m_tag   <= cur_tag;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (accept_o !== m_acc || valid_o !== m_valid || vector_o !== m_vec) begin
        n_err++;
        $display("FAIL %s model: acc=%b/%b valid=%b/%b vec=%h/%h (actual/expected)",
                 m_tag, accept_o, m_acc, valid_o, m_valid, vector_o, m_vec);
      end
    end
  end

  task automatic check(string tag, logic [N-1:0] exp_acc, logic exp_v, logic [VW-1:0] exp_vec);
    n_chk++;
    if (accept_o !== exp_acc || valid_o !== exp_v || vector_o !== exp_vec) begin
      n_err++;
      $display("FAIL %s: acc=%b valid=%b vec=%h expected acc=%b valid=%b vec=%h",
               tag, accept_o, valid_o, vector_o, exp_acc, exp_v, exp_vec);
    end
  endtask

  task automatic send(string tag, logic [IDW-1:0] d, logic lg, logic [1:0] s,
                      logic [N-1:0] snd, logic [VW-1:0] v, logic [N-1:0] exp_acc);
    cur_tag = tag;
    req_valid = 1'b1; dest = d; logical = lg; sh = s; sender = snd; vec = v;
    @(negedge clk);
    check(tag, exp_acc, 1'b1, v);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    pid = {32'h0001_0005, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000};
    lid = {8'h08, 8'h04, 8'h02, 8'h01};
    repeat (3) @(negedge clk);
    check("R2", '0, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0, '0);

    // physical, compatible
    send("R6 alias", 32'h0000_0001, 0, 2'd0, '0, 8'h41, 4'b0110);
    send("R6 upper ignored", 32'hFFFF_FF05, 0, 2'd0, '0, 8'h42, 4'b1000);
    send("R13 absent id", 32'h0000_0007, 0, 2'd0, '0, 8'h43, 4'b0000);
    send("R7", 32'h0000_00FF, 0, 2'd0, '0, 8'h44, 4'b1111);
    send("R14 sender ignored", 32'h0000_0000, 0, 2'd0, 4'b0110, 8'h45, 4'b0001);
    send("R14 sender no add", 32'h0000_0007, 0, 2'd0, 4'b1111, 8'h46, 4'b0000);
    // R1: idle cycle holds vector, clears accept
    @(negedge clk);
    check("R1 idle", '0, 1'b0, 8'h46);

    // physical, extended
    ext = 1'b1;
    send("R8 ff not bcast", 32'h0000_00FF, 0, 2'd0, '0, 8'h50, 4'b0000);
    send("R8 full id", 32'h0001_0005, 0, 2'd0, '0, 8'h51, 4'b1000);
    send("R8 low byte only", 32'h0000_0005, 0, 2'd0, '0, 8'h52, 4'b0000);
    send("R8 bcast", 32'hFFFF_FFFF, 0, 2'd0, '0, 8'h53, 4'b1111);
    send("R9 ext logical", 32'h0000_0005, 1, 2'd0, '0, 8'h54, 4'b0101);
    ext = 1'b0;

    // logical flat
    send("R9 flat", 32'h0000_0005, 1, 2'd0, '0, 8'h60, 4'b0101);
    send("R13 flat extra bits", 32'h0000_00F2, 1, 2'd0, '0, 8'h61, 4'b0010);
    send("R11 flat bcast", 32'h0000_00FF, 1, 2'd0, '0, 8'h62, 4'b1111);

    // logical cluster
    clus = 4'b1111;
    lid = {8'h14, 8'h21, 8'h12, 8'h11};
    send("R10 members", 32'h0000_0013, 1, 2'd0, '0, 8'h70, 4'b0011);
    send("R10 other cluster", 32'h0000_0021, 1, 2'd0, '0, 8'h71, 4'b0100);
    send("R10 cluster mismatch", 32'h0000_0031, 1, 2'd0, '0, 8'h72, 4'b0000);
    send("R13 absent member", 32'h0000_0018, 1, 2'd0, '0, 8'h73, 4'b0000);
    send("R11 cluster bcast", 32'h0000_00FF, 1, 2'd0, '0, 8'h74, 4'b1111);

    // mixed formats
    clus = 4'b1100;
    lid = {8'h14, 8'h21, 8'h12, 8'h01};
    send("R12 mixed a", 32'h0000_0012, 1, 2'd0, '0, 8'h80, 4'b0010);
    send("R12 mixed b", 32'h0000_0014, 1, 2'd0, '0, 8'h81, 4'b1010);

    // shorthands, destination set to something that would match otherwise
    send("R3 self", 32'h0000_0001, 0, 2'd1, 4'b0100, 8'h90, 4'b0100);
    send("R4 all incl", 32'h0000_0007, 0, 2'd2, 4'b0001, 8'h91, 4'b1111);
    send("R5 all excl", 32'h0000_00FF, 1, 2'd3, 4'b0001, 8'h92, 4'b1110);
    send("R5 all excl hi", 32'h0000_0000, 0, 2'd3, 4'b1000, 8'h93, 4'b0111);

    // back to back, no gap
    cur_tag = "R1 b2b";
    req_valid = 1'b1; dest = 32'h0000_0000; logical = 0; sh = 2'd0; sender = '0; vec = 8'hA0;
    @(negedge clk);
    check("R1 b2b first", 4'b0001, 1'b1, 8'hA0);
    dest = 32'h0000_0001; vec = 8'hA1;
    @(negedge clk);
    check("R1 b2b second", 4'b0110, 1'b1, 8'hA1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 after", '0, 1'b0, 8'hA1);

    rst_n = 1'b0;
    @(negedge clk);
    check("R2 re-reset", '0, 1'b0, '0);
    finish_run();
  end
endmodule